// File: doc/BRIEF.md
# Standby Wake and PLL Clock Hand-over Controller

This controller manages a low-power standby state in which only the main oscillator and a free-running timebase counter stay active. A standby request, accepted only while the system runs on the PLL clock, stops the PLL and halts the CPU. Two causes end standby. The first is an active-low external reset. The second is a peripheral interrupt whose 3-bit level is anything except the "disabled" code 3'b111.

When standby ends, the PLL is enabled at once and the CPU resumes on the main clock. The block then measures the PLL settling time without a dedicated timer. It watches bit `TB_BIT` of the timebase counter, which is never cleared on wake. It waits first for a falling edge of that bit and then for the next rising edge. Only after that rising edge does it move the clock select to the PLL. The counter phase at wake is arbitrary, so the settling wait varies between roughly one and three half-periods of the monitored bit.

A latched wake-cause flag reports whether the last release came from the external reset or from an interrupt. Acceptance and servicing of the interrupt itself are left to the CPU.

Top module: `tmwake_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are `pll_en`=1, `clk_sel_pll`=0, `pll_selected`=0, `wake_by_irq`=0, and `cpu_run`=1 when `ext_rst_n` is high. After `rst_n` rises, `clk_sel_pll` first reads 1 after exactly 2^TB_BIT+1 clock edges.
- R2: A `stby_req` sampled high while `clk_sel_pll`=1 enters standby at the next edge, giving `pll_en`=0, `clk_sel_pll`=0 and `cpu_run`=0.
- R3: In standby, `irq_valid`=1 with `irq_level` other than 3'b111 leaves standby at the next edge: `pll_en`=1, `clk_sel_pll`=0 and `cpu_run`=1.
- R4: In standby, an interrupt with level 3'b111 or with `irq_valid`=0, together with `ext_rst_n` high, leaves the block in standby (`pll_en` stays 0).
- R5: In standby, `ext_rst_n`=0 leaves standby at the next edge (`pll_en`=1, `clk_sel_pll`=0). `cpu_run` is 0 whenever `ext_rst_n` is 0.
- R6: On each release, `wake_by_irq` is loaded with 0 for an external-reset wake and 1 for an interrupt wake. A reset takes priority when both are present. The value is held until the next release.
- R7: After a release, `clk_sel_pll` stays 0 until a falling edge and then a rising edge of timebase bit TB_BIT have been seen. The count of cycles spent with `pll_en`=1 and `clk_sel_pll`=0 lies between 2^TB_BIT+1 and 3*2^TB_BIT.
- R8: `pll_selected` always equals `clk_sel_pll` in the same cycle.
- R9: A `stby_req` that arrives while the PLL wait is in progress is ignored and is not remembered after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Power-on reset, active low |
| stby_req | input | 1 | Request to enter standby |
| ext_rst_n | input | 1 | External reset pin, active low; wakes from standby |
| irq_valid | input | 1 | Peripheral interrupt request |
| irq_level | input | 3 | Interrupt level; 3'b111 means disabled |
| pll_en | output | 1 | PLL enable |
| clk_sel_pll | output | 1 | System clock select: 0 main, 1 PLL |
| pll_selected | output | 1 | Flags that the PLL clock is in use |
| cpu_run | output | 1 | CPU allowed to execute |
| wake_by_irq | output | 1 | Cause of last release: 0 reset, 1 interrupt |

## Verification
Standby entry and release each show up one edge after the input is sampled. The bench therefore drives inputs on a falling edge and checks the result on the next falling edge. The cause flag moves on the same edge as the release. The clock hand-over has no fixed delay, so the bench counts the falling-edge samples spent in the wait and checks that count against the R7 window. Standby is entered after a different number of idle cycles each time, so the counter phase differs from one wake to the next.

// File: rtl/tmwake_ctrl.sv
module tmwake_ctrl #(
  parameter int TB_BIT = 13,
  parameter logic [2:0] LVL_OFF = 3'b111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req,
  input  logic       ext_rst_n,
  input  logic       irq_valid,
  input  logic [2:0] irq_level,
  output logic       pll_en,
  output logic       clk_sel_pll,
  output logic       pll_selected,
  output logic       cpu_run,
  output logic       wake_by_irq
);
  localparam int CNT_W = TB_BIT + 1;

  typedef enum logic [1:0] {
    ST_PLL   = 2'd0,
    ST_STBY  = 2'd1,
    ST_WFALL = 2'd2,
    ST_WRISE = 2'd3
  } st_t;

  st_t st_q, st_d;
  logic [CNT_W-1:0] tb_cnt;
  logic mon_q, cause_q;
  logic mon_now, mon_fall, mon_rise;
  logic irq_wake, rst_wake, wake;

  assign mon_now  = tb_cnt[TB_BIT];
  assign mon_fall = mon_q & ~mon_now;
  assign mon_rise = ~mon_q & mon_now;
  assign irq_wake = irq_valid && (irq_level != LVL_OFF);
  assign rst_wake = ~ext_rst_n;
  assign wake     = rst_wake | irq_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_cnt <= '0;
      mon_q  <= 1'b1;
    end else begin
      tb_cnt <= tb_cnt + 1'b1;
      mon_q  <= mon_now;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PLL:   if (stby_req) st_d = ST_STBY;
      ST_STBY:  if (wake)     st_d = ST_WFALL;
      ST_WFALL: if (mon_fall) st_d = ST_WRISE;
      ST_WRISE: if (mon_rise) st_d = ST_PLL;
      default:                st_d = ST_WFALL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_WFALL;
      cause_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_STBY && wake) cause_q <= ~rst_wake;
    end
  end

  assign pll_en       = (st_q != ST_STBY);
  assign clk_sel_pll  = (st_q == ST_PLL);
  assign pll_selected = clk_sel_pll;
  assign cpu_run      = (st_q != ST_STBY) && ext_rst_n;
  assign wake_by_irq  = cause_q;
endmodule

// File: rtl/tmwake_ctrl_chk.sv
module tmwake_ctrl_chk #(
  parameter int TB_BIT = 13
) (
  input logic       clk,
  input logic       rst_n,
  input logic       stby_req,
  input logic       ext_rst_n,
  input logic       irq_valid,
  input logic [2:0] irq_level,
  input logic       pll_en,
  input logic       clk_sel_pll,
  input logic       cpu_run,
  input logic       wake_by_irq
);
  localparam int HALF  = 1 << TB_BIT;
  localparam int LAT_W = TB_BIT + 3;

  logic [LAT_W-1:0] lat;
  logic waking;
  assign waking = !ext_rst_n || (irq_valid && irq_level != 3'b111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else if (pll_en && !clk_sel_pll) lat <= lat + 1'b1;
    else lat <= '0;
  end

  // R2
  stby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_pll && stby_req) |=> (!pll_en && !clk_sel_pll && !cpu_run));
  // R4
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en && !waking) |=> !pll_en);
  // R3
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en && waking) |=> (pll_en && !clk_sel_pll));
  // R6
  cause_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en && !ext_rst_n) |=> !wake_by_irq);
  // R6
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en && $past(pll_en)) |-> $stable(wake_by_irq));
  // R7
  lat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel_pll) |-> (lat >= LAT_W'(HALF + 1) && lat <= LAT_W'(3 * HALF)));
  // R9
  stby_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en && !clk_sel_pll && stby_req) |=> pll_en);
  // R5
  cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rst_n |-> !cpu_run);
endmodule

bind tmwake_ctrl tmwake_ctrl_chk #(.TB_BIT(TB_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .ext_rst_n(ext_rst_n),
  .irq_valid(irq_valid), .irq_level(irq_level), .pll_en(pll_en),
  .clk_sel_pll(clk_sel_pll), .cpu_run(cpu_run), .wake_by_irq(wake_by_irq)
);

// File: tb/tmwake_ctrl_tb_top.sv
module tmwake_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int TBB   = 3;
  localparam int H     = 1 << TBB;

  logic clk = 1'b0;
  logic rst_n = 1'b0, stby_req = 1'b0, ext_rst_n = 1'b1, irq_valid = 1'b0;
  logic [2:0] irq_level = 3'b111;
  logic pll_en, clk_sel_pll, pll_selected, cpu_run, wake_by_irq;
  int nchk = 0, nfail = 0;

  always #(CLK_P/2) clk = ~clk;

  tmwake_ctrl #(.TB_BIT(TBB)) dut_i (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .ext_rst_n(ext_rst_n),
    .irq_valid(irq_valid), .irq_level(irq_level), .pll_en(pll_en),
    .clk_sel_pll(clk_sel_pll), .pll_selected(pll_selected),
    .cpu_run(cpu_run), .wake_by_irq(wake_by_irq)
  );

  // {irq_valid, level[2:0], ext reset low, expect wake, expect cause}
  localparam logic [6:0] VEC [8] = '{
    {1'b1, 3'd0, 1'b0, 1'b1, 1'b1},
    {1'b1, 3'd6, 1'b0, 1'b1, 1'b1},
    {1'b1, 3'd7, 1'b0, 1'b0, 1'b0},
    {1'b0, 3'd3, 1'b0, 1'b0, 1'b0},
    {1'b0, 3'd7, 1'b1, 1'b1, 1'b0},
    {1'b1, 3'd2, 1'b1, 1'b1, 1'b0},
    {1'b1, 3'd5, 1'b0, 1'b1, 1'b1},
    {1'b1, 3'd7, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // counts wait samples; the current sample is the first wait sample
  task automatic wait_switch(output int n);
    n = 1;
    for (int k = 0; k < 10000; k++) begin
      @(negedge clk);
      chk(pll_selected == clk_sel_pll, "R8 pll_selected", pll_selected, clk_sel_pll);
      if (clk_sel_pll) break;
      n++;
    end
  endtask

  task automatic enter_stby();
    stby_req = 1'b1;
    @(negedge clk);
    stby_req = 1'b0;
    chk(!pll_en && !clk_sel_pll && !cpu_run, "R2 standby entry",
        {pll_en, clk_sel_pll, cpu_run}, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(pll_en && !clk_sel_pll && !pll_selected && !wake_by_irq && cpu_run,
        "R1 reset state", {pll_en, clk_sel_pll, pll_selected, wake_by_irq, cpu_run}, 5'b10001);
    rst_n = 1'b1;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      n++;
      if (clk_sel_pll) break;
    end
    chk(n == H + 1, "R1 power-on switch delay", n, H + 1);

    for (int i = 0; i < 8; i++) begin
      repeat (i * 3) @(negedge clk);
      enter_stby();
      irq_valid = VEC[i][6];
      irq_level = VEC[i][5:3];
      ext_rst_n = ~VEC[i][2];
      @(negedge clk);
      chk(pll_en == VEC[i][1], "R3/R4/R5 wake decision", pll_en, VEC[i][1]);
      if (VEC[i][1]) begin
        chk(wake_by_irq == VEC[i][0], "R6 wake cause", wake_by_irq, VEC[i][0]);
        chk(!clk_sel_pll, "R7 main clock after wake", clk_sel_pll, 0);
        if (VEC[i][2]) chk(!cpu_run, "R5 cpu held in reset", cpu_run, 0);
        else chk(cpu_run, "R3 cpu runs at once", cpu_run, 1);
        irq_valid = 1'b0; irq_level = 3'b111; ext_rst_n = 1'b1;
        wait_switch(n);
        chk(n >= H + 1 && n <= 3 * H, "R7 wait window", n, 2 * H);
        chk(wake_by_irq == VEC[i][0], "R6 cause held", wake_by_irq, VEC[i][0]);
      end else begin
        @(negedge clk);
        chk(!pll_en && !cpu_run, "R4 still in standby", pll_en, 0);
        irq_valid = 1'b0; ext_rst_n = 1'b1;
        irq_level = 3'd1; irq_valid = 1'b1;
        @(negedge clk);
        irq_valid = 1'b0; irq_level = 3'b111;
        chk(pll_en, "R3 level 1 wakes", pll_en, 1);
        wait_switch(n);
      end
    end

    // R9: standby request during the PLL wait is dropped
    enter_stby();
    irq_valid = 1'b1; irq_level = 3'd4;
    @(negedge clk);
    irq_valid = 1'b0; irq_level = 3'b111;
    stby_req = 1'b1;
    @(negedge clk);
    chk(pll_en && !clk_sel_pll, "R9 request ignored in wait", pll_en, 1);
    @(negedge clk);
    chk(pll_en && !clk_sel_pll, "R9 request ignored in wait", pll_en, 1);
    stby_req = 1'b0;
    wait_switch(n);
    chk(n >= H - 1 && n <= 3 * H, "R7 wait window after ignored request", n, 2 * H);
    @(negedge clk);
    chk(pll_en && clk_sel_pll, "R9 request not remembered", {pll_en, clk_sel_pll}, 3);

    // R6: interrupt and reset together, reset wins
    enter_stby();
    irq_valid = 1'b1; irq_level = 3'd0; ext_rst_n = 1'b0;
    @(negedge clk);
    irq_valid = 1'b0; irq_level = 3'b111; ext_rst_n = 1'b1;
    chk(pll_en && !wake_by_irq, "R6 reset priority", wake_by_irq, 0);
    wait_switch(n);
    chk(n >= H + 1 && n <= 3 * H, "R7 wait window", n, 2 * H);

    summary();
  end
endmodule